// File: doc/BRIEF.md
# Privileged Processor Status Register

This block holds a processor's 16-bit status word. The word has a low half that any program may write and a high half that only supervisor code may write. Two update paths feed it besides software writes. A compare path takes two 32-bit operands and derives equality, signed less-than and unsigned less-than flags, always judging the second operand against the first. An arithmetic path records carry/borrow and overflow. The mode bits in the high half drive other units through dedicated outputs.

A floating-point compare does not use the operand buses. The caller supplies an external equal/less pair, and the unsigned flag is forced low. A high-half write attempted from user mode is discarded and raises a one-cycle privilege-violation pulse. All state changes take effect at the rising clock edge and become visible on the outputs after that edge.

Top module: `psr_unit`

## Requirements
- R1: A synchronous active-high reset clears the whole word to 0x0000, which is supervisor mode (U=0), and clears the violation output.
- R2: Bit layout: C=0, T=1, L=2, J=3, K=4, F=5, Z=6, N=7, U=8, S=9, P=10, I=11. Bits 3, 4 and 15:12 always read 0 and ignore writes.
- R3: With `lo_wr` high, bits 7:0 take `wr_data[7:0]` (J and K excepted) at the next edge, whatever the mode.
- R4: With `hi_wr` high and U=0, bits 11:8 take `wr_data[11:8]` at the next edge.
- R5: With `hi_wr` high and U=1, the high half stays unchanged. `priv_fault` is 1 for exactly the cycle after that edge, and is 0 in every other cycle.
- R6: An integer compare (`cmp_en`=1, `cmp_fp`=0) sets Z to 1 when `op_b` equals `op_a`, and to 0 otherwise.
- R7: An integer compare sets N to 1 exactly when `op_b` < `op_a` as two's-complement signed values.
- R8: An integer compare sets L to 1 exactly when `op_b` < `op_a` as unsigned values.
- R9: A floating-point compare (`cmp_fp`=1) loads Z from `fp_eq`, loads N from `fp_lt`, and clears L.
- R10: With `arith_en` high, C takes `carry_in` and F takes `ovf_in`.
- R11: A low-half write in the same cycle as a compare or arithmetic update wins over both on bits 7:0.
- R12: `user_mode`, `stack_sel`, `trace_pend` and `int_en` equal bits U, S, P and I of the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lo_wr | input | 1 | Write request for bits 7:0 |
| hi_wr | input | 1 | Write request for bits 15:8 |
| wr_data | input | 16 | Write data |
| cmp_en | input | 1 | Compare result update |
| cmp_fp | input | 1 | Compare is floating point |
| op_a | input | 32 | First compare operand |
| op_b | input | 32 | Second compare operand |
| fp_eq | input | 1 | External floating-point equal result |
| fp_lt | input | 1 | External floating-point less result |
| arith_en | input | 1 | Carry/overflow update |
| carry_in | input | 1 | Carry or borrow value |
| ovf_in | input | 1 | Overflow value |
| psr_q | output | 16 | Status word |
| user_mode | output | 1 | U bit |
| stack_sel | output | 1 | S bit |
| trace_pend | output | 1 | P bit |
| int_en | output | 1 | I bit |
| priv_fault | output | 1 | One-cycle privilege violation pulse |

## Verification
The hardest situation to reach is a rejected high-half write. The word must first be moved into user mode through a legal supervisor write, and only then can the blocked write and its single-cycle pulse be observed. The stimulus does this and then, still in user mode, issues a low-half write to show that the low half remains writable. The compare vectors sit on the sign boundary (0x7FFFFFFF against 0x80000000, and -1 against 1) so that the signed and unsigned flags disagree.

// File: rtl/psr_pkg.sv
package psr_pkg;

    localparam int WORD_W = 16;
    localparam int HALF_W = WORD_W / 2;

    typedef struct packed {
        logic [3:0] rsv;
        logic       i;
        logic       p;
        logic       s;
        logic       u;
        logic       n;
        logic       z;
        logic       f;
        logic       k;
        logic       j;
        logic       l;
        logic       t;
        logic       c;
    } psr_t;

    typedef struct packed {
        logic z;
        logic n;
        logic l;
    } cmp_flags_t;

    // Clear every bit that must read zero.
    function automatic psr_t psr_scrub(input psr_t v);
        psr_t r;
        r     = v;
        r.rsv = '0;
        r.j   = 1'b0;
        r.k   = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/psr_cmp.sv
module psr_cmp
    import psr_pkg::*;
#(
    parameter int OP_W   = 32,
    parameter bit HAS_FP = 1'b1
) (
    input  logic [OP_W-1:0] op_a,
    input  logic [OP_W-1:0] op_b,
    input  logic            is_fp,
    input  logic            fp_eq,
    input  logic            fp_lt,
    output cmp_flags_t      flags
);

    cmp_flags_t int_f;

    always_comb begin
        int_f.z = (op_b == op_a);
        int_f.n = ($signed(op_b) < $signed(op_a));
        int_f.l = (op_b < op_a);
    end

    generate
        if (HAS_FP) begin : g_fp
            always_comb begin
                if (is_fp) begin
                    flags.z = fp_eq;
                    flags.n = fp_lt;
                    flags.l = 1'b0;
                end else begin
                    flags = int_f;
                end
            end
        end else begin : g_nofp
            logic unused_fp;
            assign unused_fp = is_fp ^ fp_eq ^ fp_lt;
            assign flags     = int_f;
        end
    endgenerate

endmodule

// File: rtl/psr_gate.sv
module psr_gate (
    input  logic lo_req,
    input  logic hi_req,
    input  logic user,
    output logic lo_we,
    output logic hi_we,
    output logic viol
);

    always_comb begin
        lo_we = lo_req;
        hi_we = hi_req & ~user;
        viol  = hi_req & user;
    end

endmodule

// File: rtl/psr_unit.sv
module psr_unit
    import psr_pkg::*;
#(
    parameter int OP_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lo_wr,
    input  logic              hi_wr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              cmp_en,
    input  logic              cmp_fp,
    input  logic [OP_W-1:0]   op_a,
    input  logic [OP_W-1:0]   op_b,
    input  logic              fp_eq,
    input  logic              fp_lt,
    input  logic              arith_en,
    input  logic              carry_in,
    input  logic              ovf_in,
    output logic [WORD_W-1:0] psr_q,
    output logic              user_mode,
    output logic              stack_sel,
    output logic              trace_pend,
    output logic              int_en,
    output logic              priv_fault
);

    psr_t       psr_r;
    psr_t       psr_n;
    cmp_flags_t cf;
    logic       lo_we;
    logic       hi_we;
    logic       viol;
    logic       fault_r;

    psr_cmp #(.OP_W(OP_W), .HAS_FP(1'b1)) u_cmp (
        .op_a  (op_a),
        .op_b  (op_b),
        .is_fp (cmp_fp),
        .fp_eq (fp_eq),
        .fp_lt (fp_lt),
        .flags (cf)
    );

    psr_gate u_gate (
        .lo_req (lo_wr),
        .hi_req (hi_wr),
        .user   (psr_r.u),
        .lo_we  (lo_we),
        .hi_we  (hi_we),
        .viol   (viol)
    );

    always_comb begin
        psr_n = psr_r;
        if (cmp_en) begin
            psr_n.z = cf.z;
            psr_n.n = cf.n;
            psr_n.l = cf.l;
        end
        if (arith_en) begin
            psr_n.c = carry_in;
            psr_n.f = ovf_in;
        end
        if (lo_we) psr_n[HALF_W-1:0]      = wr_data[HALF_W-1:0];
        if (hi_we) psr_n[WORD_W-1:HALF_W] = wr_data[WORD_W-1:HALF_W];
        psr_n = psr_scrub(psr_n);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            psr_r   <= '0;
            fault_r <= 1'b0;
        end else begin
            psr_r   <= psr_n;
            fault_r <= viol;
        end
    end

    assign psr_q      = psr_r;
    assign user_mode  = psr_r.u;
    assign stack_sel  = psr_r.s;
    assign trace_pend = psr_r.p;
    assign int_en     = psr_r.i;
    assign priv_fault = fault_r;

endmodule

// File: rtl/psr_unit_chk.sv
module psr_unit_chk #(
    parameter int OP_W = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            lo_wr,
    input logic            hi_wr,
    input logic            cmp_en,
    input logic            cmp_fp,
    input logic            arith_en,
    input logic [OP_W-1:0] op_a,
    input logic [OP_W-1:0] op_b,
    input logic [15:0]     psr_q,
    input logic            user_mode,
    input logic            priv_fault
);

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (psr_q[4:3] == 2'b00) && (psr_q[15:12] == 4'h0));

    // R5
    hi_locked_chk: assert property (@(posedge clk) disable iff (rst)
        user_mode |=> $stable(psr_q[11:8]));

    // R5
    fault_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (hi_wr && user_mode) |=> priv_fault);

    // R5
    fault_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !(hi_wr && user_mode) |=> !priv_fault);

    // R6
    int_eq_chk: assert property (@(posedge clk) disable iff (rst)
        (cmp_en && !cmp_fp && !lo_wr) |=> (psr_q[6] == ($past(op_a) == $past(op_b))));

    // R8
    int_ult_chk: assert property (@(posedge clk) disable iff (rst)
        (cmp_en && !cmp_fp && !lo_wr) |=> (psr_q[2] == ($past(op_b) < $past(op_a))));

    // R9
    fp_l_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (cmp_en && cmp_fp && !lo_wr) |=> !psr_q[2]);

    // R12
    mode_out_chk: assert property (@(posedge clk) disable iff (rst)
        user_mode == psr_q[8]);

endmodule

bind psr_unit psr_unit_chk #(.OP_W(OP_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .lo_wr      (lo_wr),
    .hi_wr      (hi_wr),
    .cmp_en     (cmp_en),
    .cmp_fp     (cmp_fp),
    .arith_en   (arith_en),
    .op_a       (op_a),
    .op_b       (op_b),
    .psr_q      (psr_q),
    .user_mode  (user_mode),
    .priv_fault (priv_fault)
);

// File: tb/sim_psr_unit.sv
`timescale 1ns/1ps
module sim_psr_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        lo_wr, hi_wr;
    logic [15:0] wr_data;
    logic        cmp_en, cmp_fp;
    logic [31:0] op_a, op_b;
    logic        fp_eq, fp_lt;
    logic        arith_en, carry_in, ovf_in;
    logic [15:0] psr_q;
    logic        user_mode, stack_sel, trace_pend, int_en, priv_fault;

    int n_run  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    psr_unit u0 (
        .clk(clk), .rst(rst), .lo_wr(lo_wr), .hi_wr(hi_wr), .wr_data(wr_data),
        .cmp_en(cmp_en), .cmp_fp(cmp_fp), .op_a(op_a), .op_b(op_b),
        .fp_eq(fp_eq), .fp_lt(fp_lt), .arith_en(arith_en),
        .carry_in(carry_in), .ovf_in(ovf_in), .psr_q(psr_q),
        .user_mode(user_mode), .stack_sel(stack_sel), .trace_pend(trace_pend),
        .int_en(int_en), .priv_fault(priv_fault)
    );

    // {op_a, op_b, Z, N, L}
    localparam logic [66:0] VEC [0:7] = '{
        {32'h0000_0005, 32'h0000_0005, 3'b100},
        {32'h0000_0005, 32'h0000_0003, 3'b011},
        {32'h0000_0003, 32'h0000_0005, 3'b000},
        {32'h0000_0001, 32'hFFFF_FFFF, 3'b010},
        {32'hFFFF_FFFF, 32'h0000_0001, 3'b001},
        {32'h8000_0000, 32'h7FFF_FFFF, 3'b001},
        {32'h7FFF_FFFF, 32'h8000_0000, 3'b010},
        {32'h0000_0000, 32'h0000_0000, 3'b100}
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic idle();
        lo_wr = 0; hi_wr = 0; wr_data = 0; cmp_en = 0; cmp_fp = 0;
        op_a = 0; op_b = 0; fp_eq = 0; fp_lt = 0;
        arith_en = 0; carry_in = 0; ovf_in = 0;
    endtask

    // drive at negedge, let one posedge pass, sample at next negedge
    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        #100000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        idle();
        rst = 1;
        @(negedge clk); @(negedge clk);
        rst = 0;
        check("R1 reset word", psr_q, 16'h0000);
        check("R1 reset fault", priv_fault, 0);

        // compare vector table
        for (int i = 0; i < 8; i++) begin
            cmp_en = 1; op_a = VEC[i][66:35]; op_b = VEC[i][34:3];
            step();
            check($sformatf("R6 Z vec%0d", i), psr_q[6], VEC[i][2]);
            check($sformatf("R7 N vec%0d", i), psr_q[7], VEC[i][1]);
            check($sformatf("R8 L vec%0d", i), psr_q[2], VEC[i][0]);
        end
        idle();

        // R9: set L first, then floating compare
        cmp_en = 1; op_a = 5; op_b = 3; step();
        cmp_fp = 1; fp_eq = 1; fp_lt = 0; step();
        check("R9 fp eq", psr_q[7:6] & 2'b11, 2'b01);
        check("R9 L cleared", psr_q[2], 0);
        fp_eq = 0; fp_lt = 1; step();
        check("R9 fp lt", psr_q[7:6], 2'b10);
        idle();

        // R10
        arith_en = 1; carry_in = 1; ovf_in = 1; step();
        check("R10 C F set", {psr_q[5], psr_q[0]}, 2'b11);
        carry_in = 0; step();
        check("R10 C clear", {psr_q[5], psr_q[0]}, 2'b10);
        idle();

        // R3 and R2
        lo_wr = 1; wr_data = 16'hF0FF; step(); idle();
        check("R3 R2 low write", psr_q, 16'h00E7);

        // R11: low write wins over compare and arith
        lo_wr = 1; wr_data = 16'h0000; cmp_en = 1; op_a = 9; op_b = 9;
        arith_en = 1; carry_in = 1; ovf_in = 1; step(); idle();
        check("R11 write wins", psr_q, 16'h0000);

        // R4 supervisor high write, R12 mode outputs
        hi_wr = 1; wr_data = 16'hF600; step(); idle();
        check("R4 high write", psr_q, 16'h0600);
        check("R12 modes", {int_en, trace_pend, stack_sel, user_mode}, 4'b0110);
        check("R5 no fault in supervisor", priv_fault, 0);
        hi_wr = 1; wr_data = 16'h0F00; step(); idle();
        check("R4 enter user", psr_q, 16'h0F00);
        check("R12 modes user", {int_en, trace_pend, stack_sel, user_mode}, 4'b1111);

        // R5 blocked write in user mode
        hi_wr = 1; wr_data = 16'h0000; step(); idle();
        check("R5 high kept", psr_q, 16'h0F00);
        check("R5 fault pulse", priv_fault, 1);
        step();
        check("R5 fault ends", priv_fault, 0);

        // R3 low write still allowed in user mode
        lo_wr = 1; wr_data = 16'h00A5; step(); idle();
        check("R3 user low write", psr_q, 16'h0FA5);

        // R1 reset from user mode
        rst = 1; step(); rst = 0;
        check("R1 reset from user", psr_q, 16'h0000);
        check("R1 supervisor", user_mode, 0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule